// File: doc/BRIEF.md
# Word-Serial Configuration Loader

This block receives configuration traffic one 12-bit word per clock on a parallel bus qualified by an active-low load enable. The first word taken in a transaction is a header: its upper three bits name a target class and its lower nine bits name an entry within that class. The block then counts in the number of data words that class needs. When the last one arrives, it emits a single-cycle write strobe carrying the class, the entry index and every data word of the transaction packed side by side.

A coefficient transaction carries one word for each of eight banks. All eight are written together, so a coefficient set never appears half-updated. A pause input freezes the transfer so that a slow source can stretch the burst. Dropping the enable mid-burst cancels the transaction. Keeping the enable low after a transaction ends lets the next header follow at once, with no gap.

Top module: `cfg_word_loader`

## Requirements
- R1: A header is taken on the first rising edge where load_n is low and pause is low, provided either load_n was high at the previous edge or the prior transaction has just completed. wr_class reports header bits 11:9 and wr_index reports header bits 8:0.
- R2: The class codes and their data word counts are: 000 coefficient with 8 words, 010 round with 4, 110 limit with 2, 100 configuration with 1, and 101 select with 1.
- R3: For class 000, data word k (k = 0..7) is the coefficient for bank k and appears at wr_data[12k+11:12k]. wr_stb is high in the cycle after the rising edge that samples the eighth data word.
- R4: For classes 100 and 101, wr_stb is high in the cycle after the edge that samples the single data word. That word appears in wr_data[11:0] and all higher bits are zero.
- R5: For classes 010 and 110, data word k appears at wr_data[12k+11:12k] and every slot above the last word is zero.
- R6: wr_stb is never high in two consecutive cycles, and it is low in the cycle after a header is taken.
- R7: While pause is high at an edge, that bus word is ignored and no state advances. The burst continues with the next unpaused word, and wr_data stays unchanged across a paused edge.
- R8: If load_n is still low after a transaction completes, the next unpaused word is taken as a new header.
- R9: If load_n is high at any edge during a burst, the burst is abandoned with no strobe, and the next low load_n starts with a header.
- R10: A header with any other class code produces no strobe, and all words up to the next high load_n are discarded.
- R11: While rst_n is low, wr_stb, wr_class, wr_index and wr_data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_n | input | 1 | Active-low load enable |
| pause | input | 1 | High freezes the transfer |
| load_word | input | 12 | Header or data word |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_class | output | 3 | Target class of the write |
| wr_index | output | 9 | Entry index of the write |
| wr_data | output | 96 | Packed data words, word k in bits 12k+11:12k |

## Verification
Every result is due exactly one cycle after the rising edge that samples the final data word. A header or a paused word never produces an output in the following cycle. The bench drives each word just after a falling edge and reads the outputs at the next falling edge. Each read therefore sees the registers updated by exactly the one rising edge that sampled that word, and the strobe check sits right after the final word. A running count of observed strobes is compared with the count the bench expects, which catches strobes issued by aborted, paused or unknown-class traffic.

// File: rtl/cfgl_pkg.sv
// Shared class codes and burst lengths for the configuration loader.
// Assumes a 3-bit class field at the top of the header word.
package cfgl_pkg;
    localparam int CLASS_W = 3;

    typedef enum logic [CLASS_W-1:0] {
        CL_COEF  = 3'b000,
        CL_ROUND = 3'b010,
        CL_CFG   = 3'b100,
        CL_SEL   = 3'b101,
        CL_LIMIT = 3'b110
    } cfg_class_e;

    // Number of data words following a header of the given class, 0 if unknown.
    function automatic logic [3:0] burst_words(input logic [CLASS_W-1:0] code);
        case (code)
            CL_COEF:        burst_words = 4'd8;
            CL_ROUND:       burst_words = 4'd4;
            CL_LIMIT:       burst_words = 4'd2;
            CL_CFG, CL_SEL: burst_words = 4'd1;
            default:        burst_words = 4'd0;
        endcase
    endfunction
endpackage

// File: rtl/cfgl_addr_decode.sv
// Splits a header word into class and index, and reports whether the class
// is known plus the index of its last data word.
// Assumes the class field occupies the top CLASS_W bits of the word.
module cfgl_addr_decode
    import cfgl_pkg::*;
#(
    parameter int WORD_W = 12,
    parameter int CNT_W  = 3
) (
    input  logic [WORD_W-1:0]         word,
    output logic [CLASS_W-1:0]        cls,
    output logic [WORD_W-CLASS_W-1:0] idx,
    output logic                      known,
    output logic [CNT_W-1:0]          last
);
    logic [3:0] words;

    // Field split and burst length lookup.
    always_comb begin
        cls   = word[WORD_W-1 -: CLASS_W];
        idx   = word[WORD_W-CLASS_W-1:0];
        words = burst_words(cls);
        known = (words != 4'd0);
        last  = known ? CNT_W'(words - 4'd1) : '0;
    end
endmodule

// File: rtl/cfgl_sequencer.sv
// Transaction sequencer: header capture, data word counting, pause hold,
// abort on enable release and discard of unknown classes.
// Assumes the decode outputs are valid on the header cycle.
module cfgl_sequencer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             pause,
    input  logic             dec_known,
    input  logic [CNT_W-1:0] dec_last,
    output logic             addr_take,
    output logic             slot_we,
    output logic [CNT_W-1:0] slot_sel,
    output logic             done
);
    typedef enum logic [1:0] {ST_ADDR, ST_DATA, ST_DROP} seq_state_e;

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_q;
    logic             active;
    logic             final_word;

    // Word acceptance qualifiers.
    always_comb begin
        active     = !load_n && !pause;
        addr_take  = active && (state == ST_ADDR);
        slot_we    = active && (state == ST_DATA);
        slot_sel   = cnt;
        final_word = slot_we && (cnt == last_q);
    end

    // State, word counter and completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            last_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= final_word;
            if (load_n) begin
                state <= ST_ADDR;
                cnt   <= '0;
            end else if (!pause) begin
                case (state)
                    ST_ADDR: begin
                        cnt    <= '0;
                        last_q <= dec_last;
                        state  <= dec_known ? ST_DATA : ST_DROP;
                    end
                    ST_DATA: begin
                        if (cnt == last_q) begin
                            state <= ST_ADDR;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DROP: state <= ST_DROP;
                    default: state <= ST_ADDR;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfgl_word_collect.sv
// Slot register file gathering the data words of one transaction.
// Cleared on each header so unused slots read as zero.
module cfgl_word_collect #(
    parameter int WORD_W = 12,
    parameter int SLOTS  = 8,
    parameter int SEL_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    we,
    input  logic [SEL_W-1:0]        sel,
    input  logic [WORD_W-1:0]       word,
    output logic [SLOTS*WORD_W-1:0] packed_o
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [WORD_W-1:0] q;

        // One slot: clear on header, load when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)                          q <= '0;
            else if (clear)                      q <= '0;
            else if (we && sel == SEL_W'(s))     q <= word;
        end

        assign packed_o[s*WORD_W +: WORD_W] = q;
    end
endmodule

// File: rtl/cfg_word_loader.sv
// Top of the word-serial configuration loader. A header word selects class
// and index; the class-dependent number of data words follows; a one-cycle
// strobe then presents all words packed. Assumes MAX_WORDS >= 8.
module cfg_word_loader
    import cfgl_pkg::*;
#(
    parameter int WORD_W    = 12,
    parameter int MAX_WORDS = 8,
    localparam int INDEX_W  = WORD_W - CLASS_W,
    localparam int CNT_W    = $clog2(MAX_WORDS),
    localparam int DATA_W   = MAX_WORDS * WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_n,
    input  logic               pause,
    input  logic [WORD_W-1:0]  load_word,
    output logic               wr_stb,
    output logic [CLASS_W-1:0] wr_class,
    output logic [INDEX_W-1:0] wr_index,
    output logic [DATA_W-1:0]  wr_data
);
    logic [CLASS_W-1:0] dec_cls;
    logic [INDEX_W-1:0] dec_idx;
    logic               dec_known;
    logic [CNT_W-1:0]   dec_last;
    logic               addr_take;
    logic               slot_we;
    logic [CNT_W-1:0]   slot_sel;
    logic               done;

    cfgl_addr_decode #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_dec (
        .word  (load_word),
        .cls   (dec_cls),
        .idx   (dec_idx),
        .known (dec_known),
        .last  (dec_last)
    );

    cfgl_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .pause     (pause),
        .dec_known (dec_known),
        .dec_last  (dec_last),
        .addr_take (addr_take),
        .slot_we   (slot_we),
        .slot_sel  (slot_sel),
        .done      (done)
    );

    cfgl_word_collect #(.WORD_W(WORD_W), .SLOTS(MAX_WORDS), .SEL_W(CNT_W)) u_col (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (addr_take),
        .we       (slot_we),
        .sel      (slot_sel),
        .word     (load_word),
        .packed_o (wr_data)
    );

    // Header fields held for the duration of the transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_class <= '0;
            wr_index <= '0;
        end else if (addr_take) begin
            wr_class <= dec_cls;
            wr_index <= dec_idx;
        end
    end

    assign wr_stb = done;
endmodule

// File: rtl/cfgl_checker.sv
// Protocol assertions for the configuration loader, bound to the top module.
module cfgl_checker #(
    parameter int WORD_W = 12,
    parameter int DATA_W = 96
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_n,
    input logic              pause,
    input logic              wr_stb,
    input logic [2:0]        wr_class,
    input logic [DATA_W-1:0] wr_data
);
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    a_r9_release_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> !wr_stb);

    a_r7_pause_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        pause |=> !wr_stb);

    a_r7_pause_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
        (pause || load_n) |=> $stable(wr_data));

    a_r2_known_class: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (wr_class inside {3'b000, 3'b010, 3'b100, 3'b101, 3'b110}));

    a_r4_single_word_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (wr_class == 3'b100 || wr_class == 3'b101))
        |-> (wr_data[DATA_W-1:WORD_W] == '0));
endmodule

bind cfg_word_loader cfgl_checker #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_n   (load_n),
    .pause    (pause),
    .wr_stb   (wr_stb),
    .wr_class (wr_class),
    .wr_data  (wr_data)
);

// File: tb/cfg_word_loader_test.sv
`timescale 1ns/1ps
module cfg_word_loader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_n = 1'b1;
    logic        pause = 1'b0;
    logic [11:0] load_word = '0;
    logic        wr_stb;
    logic [2:0]  wr_class;
    logic [8:0]  wr_index;
    logic [95:0] wr_data;

    int checks = 0;
    int failures = 0;
    int seen_strobes = 0;
    int exp_strobes = 0;
    logic [11:0] wbuf [8];

    always #2 clk = ~clk;

    cfg_word_loader uut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .pause(pause),
        .load_word(load_word), .wr_stb(wr_stb), .wr_class(wr_class),
        .wr_index(wr_index), .wr_data(wr_data)
    );

    // Strobe counter sampled away from the active edge.
    always @(negedge clk) if (rst_n && wr_stb) seen_strobes++;

    function automatic int exp_len(input logic [2:0] c);
        case (c)
            3'b000: return 8;
            3'b010: return 4;
            3'b110: return 2;
            3'b100, 3'b101: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [95:0] exp_pack(input int n);
        logic [95:0] v = '0;
        for (int k = 0; k < n; k++) v[12*k +: 12] = wbuf[k];
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one word after a falling edge, return at the next falling edge.
    task automatic cyc(input logic l, input logic p, input logic [11:0] w);
        load_n = l; pause = p; load_word = w;
        @(negedge clk);
    endtask

    task automatic maybe_pause(input int pct);
        while ($urandom_range(99) < pct) begin
            cyc(1'b0, 1'b1, 12'($urandom));
            chk(wr_stb == 1'b0, "R7", {95'd0, wr_stb}, 96'd0);
        end
    endtask

    task automatic txn(input logic [2:0] c, input logic [8:0] idx, input int pct, input string req);
        int n = exp_len(c);
        maybe_pause(pct);
        cyc(1'b0, 1'b0, {c, idx});
        chk(wr_stb == 1'b0, "R6", {95'd0, wr_stb}, 96'd0);
        for (int k = 0; k < n; k++) begin
            wbuf[k] = 12'($urandom);
            maybe_pause(pct);
            cyc(1'b0, 1'b0, wbuf[k]);
            if (k < n - 1) chk(wr_stb == 1'b0, req, {95'd0, wr_stb}, 96'd0);
        end
        chk(wr_stb == 1'b1, req, {95'd0, wr_stb}, 96'd1);
        chk(wr_class == c, "R1", {93'd0, wr_class}, {93'd0, c});
        chk(wr_index == idx, "R1", {87'd0, wr_index}, {87'd0, idx});
        chk(wr_data == exp_pack(n), req, wr_data, exp_pack(n));
        exp_strobes++;
    endtask

    function automatic logic [2:0] pick_class();
        case ($urandom_range(4))
            0: return 3'b000;
            1: return 3'b010;
            2: return 3'b110;
            3: return 3'b100;
            default: return 3'b101;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R11: reset state with busy inputs
        load_n = 1'b0; load_word = 12'hFFF;
        repeat (3) @(negedge clk);
        chk(wr_stb == 0 && wr_class == 0 && wr_index == 0 && wr_data == 0, "R11",
            wr_data, 96'd0);
        rst_n = 1'b1; load_n = 1'b1;
        cyc(1'b1, 1'b0, 12'h000);

        // R3 / R1: coefficient header 0x00F; R5 limit header 0xC0A
        txn(3'b000, 9'd15, 0, "R3");
        cyc(1'b1, 1'b0, 12'h000);
        txn(3'b110, 9'd10, 0, "R5");
        cyc(1'b1, 1'b0, 12'h000);
        txn(3'b101, 9'd3, 0, "R4");
        // R8: back-to-back, load_n kept low
        txn(3'b100, 9'd0, 0, "R8");
        txn(3'b010, 9'd511, 0, "R8");
        txn(3'b000, 9'd200, 0, "R8");
        // R7: heavy pause inside a coefficient burst
        txn(3'b000, 9'd77, 50, "R7");

        // R9: abort after three coefficient words
        cyc(1'b1, 1'b0, 12'h000);
        cyc(1'b0, 1'b0, 12'h005);
        for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0, 12'($urandom));
        cyc(1'b1, 1'b0, 12'hABC);
        chk(wr_stb == 1'b0, "R9", {95'd0, wr_stb}, 96'd0);
        // R9: release in place of the eighth word
        cyc(1'b0, 1'b0, 12'h006);
        for (int k = 0; k < 7; k++) cyc(1'b0, 1'b0, 12'($urandom));
        cyc(1'b1, 1'b0, 12'h123);
        chk(wr_stb == 1'b0, "R9", {95'd0, wr_stb}, 96'd0);
        txn(3'b010, 9'd6, 0, "R9");

        // R10: unknown class swallows words until release
        cyc(1'b1, 1'b0, 12'h000);
        cyc(1'b0, 1'b0, {3'b001, 9'd4});
        for (int k = 0; k < 10; k++) begin
            cyc(1'b0, 1'b0, {3'b101, 9'(k)});
            chk(wr_stb == 1'b0, "R10", {95'd0, wr_stb}, 96'd0);
        end
        cyc(1'b1, 1'b0, 12'h000);
        cyc(1'b0, 1'b0, {3'b111, 9'd1});
        cyc(1'b0, 1'b0, 12'h0AA);
        chk(wr_stb == 1'b0, "R10", {95'd0, wr_stb}, 96'd0);
        cyc(1'b1, 1'b0, 12'h000);
        txn(3'b100, 9'd9, 0, "R10");

        // Random mix of classes, pauses and idle gaps
        for (int t = 0; t < 200; t++) begin
            logic [2:0] c = pick_class();
            string tag = (c == 3'b000) ? "R3" : (c[2:1] == 2'b10) ? "R4" : "R5";
            if ($urandom_range(99) < 30) cyc(1'b1, 1'b0, 12'($urandom));
            txn(c, 9'($urandom), 15, tag);
        end
        cyc(1'b1, 1'b0, 12'h000);
        cyc(1'b1, 1'b0, 12'h000);
        chk(seen_strobes == exp_strobes, "R6",
            96'(seen_strobes), 96'(exp_strobes));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule